// File: doc/BRIEF.md
# Bridge Transaction Sorter with Delayed Request Queue

This block sits on the initiator side of a bus bridge. Every request presented on its initiator port is sorted by its 4-bit command code into one of three ordering classes. Memory writes and invalidating memory writes are posted: they are accepted in the same cycle and their command, address, byte enables and data go into a posted buffer toward the target side. I/O and configuration writes, and all read flavours, are non-posted. They are answered with retry and recorded in a small delayed transaction queue. The queue sends them to the target side in arrival order. The remaining command codes are not claimed.

When the target side finishes a queued request, it returns a completion through a reverse-direction port. The completion is tagged with the queue slot it belongs to and carries read data and an error flag. The initiator's next attempt with the same command, address and byte enables then finishes. That attempt receives the completion data and error flag, and the slot is released. Repeats that arrive before the completion only see retry again, and they never create a second copy of the request.

Top module: `bridge_txn_sorter`

## Requirements
- R1: Commands 0111 (memory write) and 1111 (memory write and invalidate) are posted. While the posted buffer has room, the request gets `rq_done`=1 and `rq_retry`=0 in the same cycle. It later appears on the posted output with unchanged command, address, byte enables and data, in acceptance order.
- R2: When the posted buffer already holds `PW_DEPTH` writes, a posted request gets `rq_retry`=1 and `rq_done`=0 and is not stored.
- R3: Commands 0011 (I/O write), 1011 (config write), 0010 (I/O read), 0110 (memory read), 1010 (config read), 1100 (read multiple) and 1110 (read line) are delayed. A first attempt gets `rq_retry`=1. The request then shows on the delayed-request output, starting the cycle after the attempt, with its slot number on `dr_tag`.
- R4: Delayed requests leave on the delayed-request output in the order they were first retried, one per `dr_valid`/`dr_ready` handshake, and hold steady while `dr_ready` is low.
- R5: A repeat attempt that matches a queued request still lacking its completion gets retry again and adds no new entry. The match is on command, address and byte enables.
- R6: After a completion has come back for a slot, a repeat attempt with the same command, address and byte enables gets `rq_done`=1 with `rq_rdata`=`cp_rdata` and `rq_err`=`cp_err` of that completion, and the slot is freed. An attempt that differs in byte enables does not finish it.
- R7: A completion is recorded only for a slot whose request has already been handed out on the delayed-request output. A completion with any other `cp_tag` has no effect.
- R8: When all `DQ_DEPTH` slots are in use, a new non-matching delayed request gets retry and is not enqueued.
- R9: Command codes outside the two classes above (0000, 0001, 0100, 0101, 1000, 1001, 1101) get neither `rq_done` nor `rq_retry` and change no state.
- R10: After reset, `pw_valid` and `dr_valid` are 0 and no request gets a response until it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Initiator attempt present this cycle |
| rq_cmd | input | 4 | Bus command code |
| rq_addr | input | ADDR_W | Attempt address |
| rq_be | input | DATA_W/8 | Byte enables |
| rq_wdata | input | DATA_W | Write data |
| rq_done | output | 1 | Attempt completes this cycle |
| rq_retry | output | 1 | Attempt is to be retried |
| rq_rdata | output | DATA_W | Completion data on a finished delayed attempt |
| rq_err | output | 1 | Completion error flag on a finished delayed attempt |
| pw_valid | output | 1 | Posted write available toward target |
| pw_ready | input | 1 | Target side takes the posted write |
| pw_cmd | output | 4 | Posted write command |
| pw_addr | output | ADDR_W | Posted write address |
| pw_be | output | DATA_W/8 | Posted write byte enables |
| pw_data | output | DATA_W | Posted write data |
| dr_valid | output | 1 | Delayed request available toward target |
| dr_ready | input | 1 | Target side takes the delayed request |
| dr_tag | output | log2(DQ_DEPTH) | Queue slot of the delayed request |
| dr_cmd | output | 4 | Delayed request command |
| dr_addr | output | ADDR_W | Delayed request address |
| dr_be | output | DATA_W/8 | Delayed request byte enables |
| dr_wdata | output | DATA_W | Delayed request write data |
| cp_valid | input | 1 | Completion returning from target side |
| cp_tag | input | log2(DQ_DEPTH) | Slot the completion belongs to |
| cp_rdata | input | DATA_W | Completion read data |
| cp_err | input | 1 | Completion error flag |

## Verification
The hardest state to reach is a slot that holds a request which has not yet gone out, while completions arrive for it. The stimulus enqueues one request and leaves `dr_ready` low. It then fires completions at every slot number, then repeats the attempt and expects retry again. Only after this does it accept the request and return the real completion. A second hard case is a full queue combined with a duplicate attempt. Four distinct reads are held back, and then a fifth read and a repeat of the first are presented. Draining the output afterwards must yield exactly the four originals, in order.

// File: rtl/brsort_pkg.sv
package brsort_pkg;

   typedef enum logic [1:0] {
      CLS_NONE    = 2'd0,
      CLS_POSTED  = 2'd1,
      CLS_DELAYED = 2'd2
   } txn_class_e;

   typedef enum logic [1:0] {
      ENT_FREE   = 2'd0,
      ENT_QUEUED = 2'd1,
      ENT_ISSUED = 2'd2,
      ENT_DONE   = 2'd3
   } ent_state_e;

   localparam logic [3:0] CMD_IO_RD    = 4'b0010;
   localparam logic [3:0] CMD_IO_WR    = 4'b0011;
   localparam logic [3:0] CMD_MEM_RD   = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR   = 4'b0111;
   localparam logic [3:0] CMD_CFG_RD   = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR   = 4'b1011;
   localparam logic [3:0] CMD_RD_MULT  = 4'b1100;
   localparam logic [3:0] CMD_RD_LINE  = 4'b1110;
   localparam logic [3:0] CMD_MEM_WINV = 4'b1111;

endpackage

// File: rtl/brsort_classify.sv
module brsort_classify
   import brsort_pkg::*;
(
   input  logic [3:0] cmd,
   output txn_class_e cls
);

   always_comb begin
      unique case (cmd)
         CMD_MEM_WR, CMD_MEM_WINV:                   cls = CLS_POSTED;
         CMD_IO_WR, CMD_CFG_WR,
         CMD_IO_RD, CMD_MEM_RD, CMD_CFG_RD,
         CMD_RD_MULT, CMD_RD_LINE:                   cls = CLS_DELAYED;
         default:                                    cls = CLS_NONE;
      endcase
   end

endmodule

// File: rtl/brsort_fifo.sv
module brsort_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("brsort_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW:0]      wr_ptr, rd_ptr;

   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
   assign dout  = mem[rd_ptr[PW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push && !full) begin
            mem[wr_ptr[PW-1:0]] <= din;
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R2
   occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) <= (PW+1)'(DEPTH));

   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !push |=> empty);

endmodule

// File: rtl/brsort_dq.sv
module brsort_dq
   import brsort_pkg::*;
#(
   parameter int NE     = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8,
   localparam int TW    = $clog2(NE)
) (
   input  logic              clk,
   input  logic              rst_n,
   // lookup from a non-posted attempt
   input  logic              lk_valid,
   input  logic [3:0]        lk_cmd,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [BE_W-1:0]   lk_be,
   input  logic [DATA_W-1:0] lk_wdata,
   output logic              lk_finish,
   output logic [DATA_W-1:0] lk_rdata,
   output logic              lk_err,
   // toward target
   output logic              dr_valid,
   input  logic              dr_ready,
   output logic [TW-1:0]     dr_tag,
   output logic [3:0]        dr_cmd,
   output logic [ADDR_W-1:0] dr_addr,
   output logic [BE_W-1:0]   dr_be,
   output logic [DATA_W-1:0] dr_wdata,
   // completion from target
   input  logic              cp_valid,
   input  logic [TW-1:0]     cp_tag,
   input  logic [DATA_W-1:0] cp_rdata,
   input  logic              cp_err
);

   generate
      if (NE < 2 || (1 << TW) != NE) begin : g_bad_ne
         $error("brsort_dq: NE must be a power of two of at least 2");
      end
   endgenerate

   ent_state_e        st      [NE];
   logic [3:0]        e_cmd   [NE];
   logic [ADDR_W-1:0] e_addr  [NE];
   logic [BE_W-1:0]   e_be    [NE];
   logic [DATA_W-1:0] e_wdata [NE];
   logic [DATA_W-1:0] e_rdata [NE];
   logic              e_err   [NE];

   logic [NE-1:0] match;
   logic [TW-1:0] hit_idx, free_idx, head_idx;
   logic          hit_any, free_any, alloc, issue, ord_full, ord_empty;

   genvar gi;
   generate
      for (gi = 0; gi < NE; gi++) begin : g_cmp
         assign match[gi] = (st[gi] != ENT_FREE) && (e_cmd[gi] == lk_cmd) &&
                            (e_addr[gi] == lk_addr) && (e_be[gi] == lk_be);
      end
   endgenerate

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      free_any = 1'b0;
      for (int i = NE-1; i >= 0; i--) begin
         if (match[i]) hit_idx = TW'(i);
         if (st[i] == ENT_FREE) begin
            free_any = 1'b1;
            free_idx = TW'(i);
         end
      end
   end

   assign hit_any   = |match;
   assign lk_finish = lk_valid && hit_any && (st[hit_idx] == ENT_DONE);
   assign lk_rdata  = lk_finish ? e_rdata[hit_idx] : '0;
   assign lk_err    = lk_finish && e_err[hit_idx];
   assign alloc     = lk_valid && !hit_any && free_any;
   assign issue     = dr_valid && dr_ready;

   brsort_fifo #(.WIDTH(TW), .DEPTH(NE)) u_order (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (alloc),
      .din   (free_idx),
      .pop   (issue),
      .dout  (head_idx),
      .full  (ord_full),
      .empty (ord_empty)
   );

   assign dr_valid = !ord_empty;
   assign dr_tag   = head_idx;
   assign dr_cmd   = e_cmd[head_idx];
   assign dr_addr  = e_addr[head_idx];
   assign dr_be    = e_be[head_idx];
   assign dr_wdata = e_wdata[head_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NE; i++) begin
            st[i]      <= ENT_FREE;
            e_cmd[i]   <= '0;
            e_addr[i]  <= '0;
            e_be[i]    <= '0;
            e_wdata[i] <= '0;
            e_rdata[i] <= '0;
            e_err[i]   <= 1'b0;
         end
      end else begin
         for (int i = 0; i < NE; i++) begin
            if (alloc && free_idx == TW'(i)) begin
               st[i]      <= ENT_QUEUED;
               e_cmd[i]   <= lk_cmd;
               e_addr[i]  <= lk_addr;
               e_be[i]    <= lk_be;
               e_wdata[i] <= lk_wdata;
            end
            if (issue && head_idx == TW'(i)) st[i] <= ENT_ISSUED;
            if (cp_valid && cp_tag == TW'(i) && st[i] == ENT_ISSUED) begin
               st[i]      <= ENT_DONE;
               e_rdata[i] <= cp_rdata;
               e_err[i]   <= cp_err;
            end
            if (lk_finish && hit_idx == TW'(i)) st[i] <= ENT_FREE;
         end
      end
   end

   // R5
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R8
   order_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !ord_full);

   generate
      for (gi = 0; gi < NE; gi++) begin : g_ent_chk
         // R7
         done_needs_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st[gi] != ENT_DONE) |=> (st[gi] != ENT_DONE) ||
                                      $past(cp_valid && cp_tag == TW'(gi)));
      end
   endgenerate

endmodule

// File: rtl/bridge_txn_sorter.sv
module bridge_txn_sorter
   import brsort_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int PW_DEPTH = 4,
   parameter int DQ_DEPTH = 4,
   localparam int BE_W    = DATA_W / 8,
   localparam int TAG_W   = $clog2(DQ_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rq_valid,
   input  logic [3:0]        rq_cmd,
   input  logic [ADDR_W-1:0] rq_addr,
   input  logic [BE_W-1:0]   rq_be,
   input  logic [DATA_W-1:0] rq_wdata,
   output logic              rq_done,
   output logic              rq_retry,
   output logic [DATA_W-1:0] rq_rdata,
   output logic              rq_err,
   output logic              pw_valid,
   input  logic              pw_ready,
   output logic [3:0]        pw_cmd,
   output logic [ADDR_W-1:0] pw_addr,
   output logic [BE_W-1:0]   pw_be,
   output logic [DATA_W-1:0] pw_data,
   output logic              dr_valid,
   input  logic              dr_ready,
   output logic [TAG_W-1:0]  dr_tag,
   output logic [3:0]        dr_cmd,
   output logic [ADDR_W-1:0] dr_addr,
   output logic [BE_W-1:0]   dr_be,
   output logic [DATA_W-1:0] dr_wdata,
   input  logic              cp_valid,
   input  logic [TAG_W-1:0]  cp_tag,
   input  logic [DATA_W-1:0] cp_rdata,
   input  logic              cp_err
);

   localparam int PF_W = 4 + ADDR_W + BE_W + DATA_W;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_dw
         $error("bridge_txn_sorter: DATA_W must be a whole number of bytes");
      end
   endgenerate

   txn_class_e        cls;
   logic              pf_full, pf_empty, pf_push;
   logic [PF_W-1:0]   pf_dout;
   logic              dq_finish, dq_err;
   logic [DATA_W-1:0] dq_rdata;

   brsort_classify u_cls (.cmd(rq_cmd), .cls(cls));

   assign pf_push = rq_valid && (cls == CLS_POSTED) && !pf_full;

   brsort_fifo #(.WIDTH(PF_W), .DEPTH(PW_DEPTH)) u_posted (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (pf_push),
      .din   ({rq_cmd, rq_addr, rq_be, rq_wdata}),
      .pop   (pw_ready),
      .dout  (pf_dout),
      .full  (pf_full),
      .empty (pf_empty)
   );

   assign pw_valid = !pf_empty;
   assign {pw_cmd, pw_addr, pw_be, pw_data} = pf_dout;

   brsort_dq #(.NE(DQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_valid  (rq_valid && cls == CLS_DELAYED),
      .lk_cmd    (rq_cmd),
      .lk_addr   (rq_addr),
      .lk_be     (rq_be),
      .lk_wdata  (rq_wdata),
      .lk_finish (dq_finish),
      .lk_rdata  (dq_rdata),
      .lk_err    (dq_err),
      .dr_valid  (dr_valid),
      .dr_ready  (dr_ready),
      .dr_tag    (dr_tag),
      .dr_cmd    (dr_cmd),
      .dr_addr   (dr_addr),
      .dr_be     (dr_be),
      .dr_wdata  (dr_wdata),
      .cp_valid  (cp_valid),
      .cp_tag    (cp_tag),
      .cp_rdata  (cp_rdata),
      .cp_err    (cp_err)
   );

   always_comb begin
      rq_done  = 1'b0;
      rq_retry = 1'b0;
      rq_rdata = '0;
      rq_err   = 1'b0;
      if (rq_valid) begin
         case (cls)
            CLS_POSTED: begin
               rq_done  = !pf_full;
               rq_retry = pf_full;
            end
            CLS_DELAYED: begin
               rq_done  = dq_finish;
               rq_retry = !dq_finish;
               rq_rdata = dq_rdata;
               rq_err   = dq_err;
            end
            default: ;
         endcase
      end
   end

   // R9
   resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rq_done && rq_retry));

   // R2
   posted_full_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid && (cls == CLS_POSTED) && pf_full |-> rq_retry && !rq_done);

   // R4
   dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid && !dr_ready |=> dr_valid && $stable(dr_tag) && $stable(dr_addr));

   // R1
   pw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw_valid && !pw_ready |=> pw_valid && $stable(pw_addr) && $stable(pw_data));

endmodule

// File: tb/bridge_txn_sorter_bench.sv
module bridge_txn_sorter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rq_valid = 1'b0;
   logic [3:0]  rq_cmd = '0;
   logic [31:0] rq_addr = '0;
   logic [3:0]  rq_be = '0;
   logic [31:0] rq_wdata = '0;
   logic        rq_done, rq_retry, rq_err;
   logic [31:0] rq_rdata;
   logic        pw_valid, pw_ready = 1'b0;
   logic [3:0]  pw_cmd, pw_be;
   logic [31:0] pw_addr, pw_data;
   logic        dr_valid, dr_ready = 1'b0;
   logic [1:0]  dr_tag;
   logic [3:0]  dr_cmd, dr_be;
   logic [31:0] dr_addr, dr_wdata;
   logic        cp_valid = 1'b0;
   logic [1:0]  cp_tag = '0;
   logic [31:0] cp_rdata = '0;
   logic        cp_err = 1'b0;

   always #4 clk = ~clk;

   bridge_txn_sorter u_bridge_txn_sorter (
      .clk(clk), .rst_n(rst_n),
      .rq_valid(rq_valid), .rq_cmd(rq_cmd), .rq_addr(rq_addr), .rq_be(rq_be),
      .rq_wdata(rq_wdata), .rq_done(rq_done), .rq_retry(rq_retry),
      .rq_rdata(rq_rdata), .rq_err(rq_err),
      .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_cmd(pw_cmd),
      .pw_addr(pw_addr), .pw_be(pw_be), .pw_data(pw_data),
      .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_tag(dr_tag),
      .dr_cmd(dr_cmd), .dr_addr(dr_addr), .dr_be(dr_be), .dr_wdata(dr_wdata),
      .cp_valid(cp_valid), .cp_tag(cp_tag), .cp_rdata(cp_rdata), .cp_err(cp_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic        g_done, g_retry, g_err;
   logic [31:0] g_rdata;
   logic [1:0]  g_tag;

   // kind: 0 unclaimed, 1 posted, 2 delayed
   typedef struct packed {
      logic [3:0]  cmd;
      logic [1:0]  kind;
      logic [31:0] addr;
      logic [31:0] data;
   } vec_t;

   localparam vec_t VT [12] = '{
      '{4'b0111, 2'd1, 32'h0000_1000, 32'hA5A5_0001},
      '{4'b1111, 2'd1, 32'h0000_1040, 32'hA5A5_0002},
      '{4'b0011, 2'd2, 32'h0000_03F8, 32'h1111_0003},
      '{4'b1011, 2'd2, 32'h0001_0010, 32'h2222_0004},
      '{4'b0010, 2'd2, 32'h0000_02E8, 32'h3333_0005},
      '{4'b0110, 2'd2, 32'h0002_0000, 32'h4444_0006},
      '{4'b1010, 2'd2, 32'h0001_0020, 32'h5555_0007},
      '{4'b1100, 2'd2, 32'h0003_0040, 32'h6666_0008},
      '{4'b1110, 2'd2, 32'h0004_0080, 32'h7777_0009},
      '{4'b0000, 2'd0, 32'h0000_0000, 32'h8888_000A},
      '{4'b1101, 2'd0, 32'h0005_0000, 32'h9999_000B},
      '{4'b0101, 2'd0, 32'h0006_0000, 32'hAAAA_000C}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rq_valid = 1'b0; pw_ready = 1'b0; dr_ready = 1'b0; cp_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic req(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                      input logic [31:0] d);
      @(negedge clk);
      rq_valid = 1'b1; rq_cmd = c; rq_addr = a; rq_be = b; rq_wdata = d;
      #1;
      g_done = rq_done; g_retry = rq_retry; g_rdata = rq_rdata; g_err = rq_err;
      @(posedge clk);
      #1 rq_valid = 1'b0;
   endtask

   task automatic take_dr(input string tag, input logic [3:0] c, input logic [31:0] a);
      @(negedge clk);
      chk(dr_valid === 1'b1, tag, {63'd0, dr_valid}, 64'd1);
      chk(dr_cmd === c && dr_addr === a, tag, {28'd0, dr_cmd, dr_addr}, {28'd0, c, a});
      g_tag = dr_tag;
      dr_ready = 1'b1;
      @(posedge clk);
      #1 dr_ready = 1'b0;
   endtask

   task automatic take_pw(input string tag, input logic [3:0] c, input logic [31:0] a,
                          input logic [31:0] d);
      @(negedge clk);
      chk(pw_valid === 1'b1 && pw_cmd === c && pw_addr === a && pw_data === d, tag,
          {pw_addr, pw_data}, {a, d});
      pw_ready = 1'b1;
      @(posedge clk);
      #1 pw_ready = 1'b0;
   endtask

   task automatic send_cp(input logic [1:0] t, input logic [31:0] d, input logic e);
      @(negedge clk);
      cp_valid = 1'b1; cp_tag = t; cp_rdata = d; cp_err = e;
      @(posedge clk);
      #1 cp_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      do_reset();
      // R10 reset state
      @(negedge clk);
      chk(pw_valid === 1'b0 && dr_valid === 1'b0 && rq_done === 1'b0 && rq_retry === 1'b0,
          "R10", {60'd0, pw_valid, dr_valid, rq_done, rq_retry}, 64'd0);

      // table walk: classification and full round trip per command
      for (int k = 0; k < 12; k++) begin
         req(VT[k].cmd, VT[k].addr, 4'hF, VT[k].data);
         if (VT[k].kind == 2'd1) begin
            chk(g_done === 1'b1 && g_retry === 1'b0, "R1", {62'd0, g_done, g_retry}, 64'd2);
            take_pw("R1", VT[k].cmd, VT[k].addr, VT[k].data);
         end else if (VT[k].kind == 2'd2) begin
            chk(g_retry === 1'b1 && g_done === 1'b0, "R3", {62'd0, g_done, g_retry}, 64'd1);
            take_dr("R3", VT[k].cmd, VT[k].addr);
            req(VT[k].cmd, VT[k].addr, 4'hF, VT[k].data);
            chk(g_retry === 1'b1 && g_done === 1'b0, "R5", {62'd0, g_done, g_retry}, 64'd1);
            send_cp(g_tag, ~VT[k].data, 1'b0);
            req(VT[k].cmd, VT[k].addr, 4'hF, VT[k].data);
            chk(g_done === 1'b1 && g_rdata === ~VT[k].data && g_err === 1'b0, "R6",
                {31'd0, g_done, g_rdata}, {31'd0, 1'b1, ~VT[k].data});
         end else begin
            chk(g_done === 1'b0 && g_retry === 1'b0, "R9", {62'd0, g_done, g_retry}, 64'd0);
            @(negedge clk);
            chk(pw_valid === 1'b0 && dr_valid === 1'b0, "R9",
                {62'd0, pw_valid, dr_valid}, 64'd0);
         end
      end

      // R2 posted buffer full, R1 order
      do_reset();
      for (int k = 0; k < 4; k++) begin
         req(4'b0111, 32'h100 + 32'(k*4), 4'hF, 32'hC0 + 32'(k));
         chk(g_done === 1'b1, "R1", {63'd0, g_done}, 64'd1);
      end
      req(4'b1111, 32'h200, 4'hF, 32'hDD);
      chk(g_retry === 1'b1 && g_done === 1'b0, "R2", {62'd0, g_done, g_retry}, 64'd1);
      for (int k = 0; k < 4; k++) take_pw("R1", 4'b0111, 32'h100 + 32'(k*4), 32'hC0 + 32'(k));
      @(negedge clk);
      chk(pw_valid === 1'b0, "R2", {63'd0, pw_valid}, 64'd0);

      // R8 queue full, R4 order, R5 no duplicate
      do_reset();
      for (int k = 0; k < 4; k++) begin
         req(4'b0110, 32'h400 + 32'(k*16), 4'hF, 32'h0);
         chk(g_retry === 1'b1, "R3", {63'd0, g_retry}, 64'd1);
      end
      req(4'b0110, 32'h500, 4'hF, 32'h0);
      chk(g_retry === 1'b1 && g_done === 1'b0, "R8", {62'd0, g_done, g_retry}, 64'd1);
      req(4'b0110, 32'h400, 4'hF, 32'h0);
      chk(g_retry === 1'b1 && g_done === 1'b0, "R5", {62'd0, g_done, g_retry}, 64'd1);
      for (int k = 0; k < 4; k++) take_dr("R4", 4'b0110, 32'h400 + 32'(k*16));
      @(negedge clk);
      chk(dr_valid === 1'b0, "R8", {63'd0, dr_valid}, 64'd0);

      // R7 early completions ignored, R6 byte-enable match and error flag
      do_reset();
      req(4'b1010, 32'h0001_0800, 4'hF, 32'h0);
      for (int t = 0; t < 4; t++) send_cp(2'(t), 32'hBAD0_0000, 1'b1);
      req(4'b1010, 32'h0001_0800, 4'hF, 32'h0);
      chk(g_retry === 1'b1 && g_done === 1'b0, "R7", {62'd0, g_done, g_retry}, 64'd1);
      take_dr("R7", 4'b1010, 32'h0001_0800);
      send_cp(g_tag, 32'h0000_0055, 1'b1);
      req(4'b1010, 32'h0001_0800, 4'h3, 32'h0);
      chk(g_retry === 1'b1 && g_done === 1'b0, "R6", {62'd0, g_done, g_retry}, 64'd1);
      req(4'b1010, 32'h0001_0800, 4'hF, 32'h0);
      chk(g_done === 1'b1 && g_rdata === 32'h55 && g_err === 1'b1, "R6",
          {30'd0, g_done, g_err, g_rdata}, {30'd0, 2'b11, 32'h55});
      req(4'b1010, 32'h0001_0800, 4'hF, 32'h0);
      chk(g_retry === 1'b1 && g_done === 1'b0, "R6", {62'd0, g_done, g_retry}, 64'd1);

      summary();
      $finish;
   end

endmodule